// File: doc/BRIEF.md
# ADC Multichannel Scan Controller

This block runs conversions across up to eight analog inputs that share one converter. It picks each channel in turn and drives a channel-select value and a one-cycle start pulse toward an external conversion engine. It then waits for the engine's done strobe and stores the returned code in that channel's result register. Each channel also has its own threshold and compare mode. A stored code that meets the compare condition sets a sticky flag for that channel.

A scan begins on an edge of one of several trigger lines. The lines are an external start pin, a timer capture/match event, a PWM sync event and the done signal of a preceding converter in a chain. Each trigger line passes through a two-flop synchroniser before the edge is detected. A scan runs either as one pass or as repeated passes. The channel mask, the scan mode, the trigger choice, the edge polarity and the per-channel thresholds all sit in a staged set. That set becomes active only when an update strobe is pulsed. A power-down input stops all activity at once.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, `busy`, `conv_start`, `scan_done` and every `cmp_flag` bit are 0, and every result field in `res_flat` is 0.
- R2: Within a pass, enabled channels are converted in ascending index order. A disabled channel gets no start pulse. `conv_chan` carries the channel index while `conv_start` is high.
- R3: When `conv_done` is high in a busy cycle, `conv_data` is stored in bits `[i*RES_W +: RES_W]` of `res_flat`, where i is the channel being converted. All other result fields are unchanged.
- R4: In single mode (`cont_mode`=0 at commit), one pass runs and `busy` then falls. `scan_done` is high for exactly one cycle, in the cycle in which the last enabled channel's result first appears.
- R5: In continuous mode (`cont_mode`=1 at commit), a new pass starts in the same cycle as `scan_done`. Passes repeat until a commit of single mode, after which the pass in progress completes and the block stops.
- R6: `trig_sel` picks `trig_in[trig_sel]`, with index 0 = external pin, 1 = timer, 2 = PWM sync and 3 = chained converter done. `trig_pol`=1 starts a scan on a rising edge and 0 on a falling edge. The first `conv_start` is high in the cycle after the third rising clock edge following the input change. The other trigger lines have no effect.
- R7: A write to address i < NCH stages channel i's compare setting: `wr_data[RES_W-1:0]` is the threshold, `wr_data[RES_W]` is the mode (1 = greater-or-equal, 0 = less-than) and `wr_data[RES_W+1]` is the compare enable. When an enabled compare is met on a store, `cmp_flag[i]` is set. The flag stays set until a write to address NCH with `wr_data[i]`=1 clears it. If a set and a clear reach the same flag in the same cycle, the set wins.
- R8: Staged writes and changes on `en_mask`, `cont_mode`, `trig_sel` and `trig_pol` have no effect on scanning or comparing until `cfg_update` is pulsed.
- R9: A trigger edge that arrives while a scan is busy is ignored. It adds no start pulse and no extra pass.
- R10: While `pwr_down` is high, the scan is abandoned: `busy` and `conv_start` are 0 from the next cycle on, triggers are ignored, and results and flags keep their values.
- R11: A trigger edge with an active channel mask of zero starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_mask | input | NCH | Channel enable mask, staged |
| cont_mode | input | 1 | 1 = continuous scan, staged |
| trig_sel | input | $clog2(NTRIG) | Trigger line select, staged |
| trig_pol | input | 1 | 1 = rising edge, 0 = falling edge, staged |
| cfg_update | input | 1 | Commits the staged configuration |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | $clog2(NCH+1) | Channel compare address, or NCH for flag clear |
| wr_data | input | max(RES_W+2, NCH) | Write data |
| trig_in | input | NTRIG | Trigger lines |
| pwr_down | input | 1 | Halts all conversion activity |
| conv_start | output | 1 | Start pulse to the conversion engine |
| conv_chan | output | $clog2(NCH) | Channel select for the conversion |
| conv_done | input | 1 | Conversion finished strobe |
| conv_data | input | RES_W | Converted code |
| res_flat | output | NCH*RES_W | Per-channel results, channel i at i*RES_W |
| cmp_flag | output | NCH | Sticky compare flags |
| scan_done | output | 1 | One-cycle end-of-pass pulse |
| busy | output | 1 | Scan in progress |

## Verification
The hardest cases to reach from the ports are those where something arrives in the middle of a pass: a new trigger edge, a commit that switches off continuous mode, or a power-down that lands between a start and its done. The bench's conversion-engine model can hold a fixed long latency, which keeps a full eight-channel pass open for dozens of cycles. The bench then lands those events while `busy` is high. In the continuous-mode test, the pass count is checked against the number of start pulses whatever pass boundary the commit lands on.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_CONV = 1'b1
  } scan_state_e;

  typedef struct packed {
    logic cmp_en;
    logic ge_mode;
  } cmp_mode_t;

  localparam int unsigned TRIG_EXT_PIN  = 0;
  localparam int unsigned TRIG_TIMER    = 1;
  localparam int unsigned TRIG_PWM_SYNC = 2;
  localparam int unsigned TRIG_CHAIN    = 3;

endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int unsigned NTRIG = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIG-1:0] trig_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             pol,
  output logic             trig_evt
);

  // two synchroniser stages plus one history stage per line
  logic [NTRIG-1:0] sync_a, sync_b, hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      hist   <= '0;
    end else begin
      sync_a <= trig_in;
      sync_b <= sync_a;
      hist   <= sync_b;
    end
  end

  logic cur_lvl, old_lvl;
  always_comb begin
    cur_lvl = 1'b0;
    old_lvl = 1'b0;
    if (int'(sel) < NTRIG) begin
      cur_lvl = sync_b[sel];
      old_lvl = hist[sel];
    end
    trig_evt = pol ? (cur_lvl & ~old_lvl) : (~cur_lvl & old_lvl);
  end

endmodule

// File: rtl/adc_cfg_bank.sv
module adc_cfg_bank
  import adc_scan_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned RES_W  = 10,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned WD     = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [WD-1:0]               wr_data,
  input  logic                        cfg_update,
  input  logic [NCH-1:0]              mask_in,
  input  logic                        cont_in,
  input  logic [SEL_W-1:0]            sel_in,
  input  logic                        pol_in,
  output logic [NCH-1:0]              act_mask,
  output logic                        act_cont,
  output logic [SEL_W-1:0]            act_sel,
  output logic                        act_pol,
  output logic [NCH-1:0][RES_W-1:0]   act_thr,
  output cmp_mode_t [NCH-1:0]         act_cmp,
  output logic [NCH-1:0]              clr_vec
);

  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(NCH);

  assign clr_vec = (wr_en && wr_addr == CLR_ADDR) ? wr_data[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mask <= '0;
      act_cont <= 1'b0;
      act_sel  <= '0;
      act_pol  <= 1'b1;
    end else if (cfg_update) begin
      act_mask <= mask_in;
      act_cont <= cont_in;
      act_sel  <= sel_in;
      act_pol  <= pol_in;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan_cfg
    logic [RES_W-1:0] thr_stg;
    cmp_mode_t        cmp_stg;
    logic             hit_addr;

    assign hit_addr = wr_en && (wr_addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_stg <= '0;
        cmp_stg <= '0;
      end else if (hit_addr) begin
        thr_stg <= wr_data[RES_W-1:0];
        cmp_stg <= '{cmp_en: wr_data[RES_W+1], ge_mode: wr_data[RES_W]};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_thr[g] <= '0;
        act_cmp[g] <= '0;
      end else if (cfg_update) begin
        act_thr[g] <= thr_stg;
        act_cmp[g] <= cmp_stg;
      end
    end
  end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_scan_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned RES_W = 10,
  parameter int unsigned CH_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      store,
  input  logic [CH_W-1:0]           store_ch,
  input  logic [RES_W-1:0]          store_data,
  input  logic [NCH-1:0][RES_W-1:0] thr,
  input  cmp_mode_t [NCH-1:0]       cmp,
  input  logic [NCH-1:0]            clr_vec,
  output logic [NCH-1:0][RES_W-1:0] res,
  output logic [NCH-1:0]            flag,
  output logic [NCH-1:0]            hit_vec
);

  function automatic logic cmp_met(input logic [RES_W-1:0] code,
                                   input logic [RES_W-1:0] limit,
                                   input cmp_mode_t        mode);
    logic below;
    below = code < limit;
    return mode.cmp_en && (mode.ge_mode ? !below : below);
  endfunction

  for (genvar g = 0; g < NCH; g++) begin : g_chan_res
    logic wr_here;
    assign wr_here    = store && (store_ch == CH_W'(g));
    assign hit_vec[g] = wr_here && cmp_met(store_data, thr[g], cmp[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res[g] <= '0;
      end else if (wr_here) begin
        res[g] <= store_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag[g] <= 1'b0;
      end else if (hit_vec[g]) begin
        flag[g] <= 1'b1;
      end else if (clr_vec[g]) begin
        flag[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int unsigned NCH  = 8,
  parameter int unsigned CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_evt,
  input  logic            pwr_down,
  input  logic [NCH-1:0]  mask,
  input  logic            cont,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [CH_W-1:0] cur_ch,
  output logic            busy,
  output logic            scan_done,
  output logic            store
);

  // lowest enabled index at or above 'from'; MSB flags a find
  function automatic logic [CH_W:0] pick_next(input logic [NCH-1:0] m,
                                              input logic [CH_W:0]  from);
    logic [CH_W:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (m[i] && (i >= int'(from))) r = {1'b1, CH_W'(i)};
    end
    return r;
  endfunction

  scan_state_e   state;
  logic [CH_W:0] first_pick, next_pick;

  assign first_pick = pick_next(mask, '0);
  assign next_pick  = pick_next(mask, {1'b0, cur_ch} + 1'b1);
  assign busy       = (state == SCAN_CONV);
  assign store      = busy && conv_done && !pwr_down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SCAN_IDLE;
      cur_ch     <= '0;
      conv_start <= 1'b0;
      scan_done  <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      scan_done  <= 1'b0;
      if (pwr_down) begin
        state <= SCAN_IDLE;
      end else begin
        unique case (state)
          SCAN_IDLE: begin
            if (trig_evt && first_pick[CH_W]) begin
              cur_ch     <= first_pick[CH_W-1:0];
              conv_start <= 1'b1;
              state      <= SCAN_CONV;
            end
          end
          SCAN_CONV: begin
            if (conv_done) begin
              if (next_pick[CH_W]) begin
                cur_ch     <= next_pick[CH_W-1:0];
                conv_start <= 1'b1;
              end else begin
                scan_done <= 1'b1;
                if (cont && first_pick[CH_W]) begin
                  cur_ch     <= first_pick[CH_W-1:0];
                  conv_start <= 1'b1;
                end else begin
                  state <= SCAN_IDLE;
                end
              end
            end
          end
          default: state <= SCAN_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned RES_W = 10,
  parameter int unsigned NTRIG = 4,
  localparam int unsigned CH_W   = $clog2(NCH),
  localparam int unsigned SEL_W  = $clog2(NTRIG),
  localparam int unsigned ADDR_W = $clog2(NCH + 1),
  localparam int unsigned WD     = (RES_W + 2 > NCH) ? RES_W + 2 : NCH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         en_mask,
  input  logic                   cont_mode,
  input  logic [SEL_W-1:0]       trig_sel,
  input  logic                   trig_pol,
  input  logic                   cfg_update,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [WD-1:0]          wr_data,
  input  logic [NTRIG-1:0]       trig_in,
  input  logic                   pwr_down,
  output logic                   conv_start,
  output logic [CH_W-1:0]        conv_chan,
  input  logic                   conv_done,
  input  logic [RES_W-1:0]       conv_data,
  output logic [NCH*RES_W-1:0]   res_flat,
  output logic [NCH-1:0]         cmp_flag,
  output logic                   scan_done,
  output logic                   busy
);

  logic [NCH-1:0]            act_mask;
  logic                      act_cont;
  logic [SEL_W-1:0]          act_sel;
  logic                      act_pol;
  logic [NCH-1:0][RES_W-1:0] act_thr;
  cmp_mode_t [NCH-1:0]       act_cmp;
  logic [NCH-1:0]            clr_vec;
  logic                      trig_evt;
  logic                      store;
  logic [NCH-1:0][RES_W-1:0] res_q;
  logic [NCH-1:0]            hit_vec;

  adc_cfg_bank #(
    .NCH(NCH), .RES_W(RES_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .WD(WD)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_update(cfg_update), .mask_in(en_mask),
    .cont_in(cont_mode), .sel_in(trig_sel), .pol_in(trig_pol),
    .act_mask(act_mask), .act_cont(act_cont), .act_sel(act_sel),
    .act_pol(act_pol), .act_thr(act_thr), .act_cmp(act_cmp),
    .clr_vec(clr_vec)
  );

  adc_trig_edge #(.NTRIG(NTRIG), .SEL_W(SEL_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sel(act_sel),
    .pol(act_pol), .trig_evt(trig_evt)
  );

  adc_scan_fsm #(.NCH(NCH), .CH_W(CH_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .trig_evt(trig_evt), .pwr_down(pwr_down),
    .mask(act_mask), .cont(act_cont), .conv_done(conv_done),
    .conv_start(conv_start), .cur_ch(conv_chan), .busy(busy),
    .scan_done(scan_done), .store(store)
  );

  adc_result_bank #(.NCH(NCH), .RES_W(RES_W), .CH_W(CH_W)) u_res (
    .clk(clk), .rst_n(rst_n), .store(store), .store_ch(conv_chan),
    .store_data(conv_data), .thr(act_thr), .cmp(act_cmp),
    .clr_vec(clr_vec), .res(res_q), .flag(cmp_flag), .hit_vec(hit_vec)
  );

  assign res_flat = res_q;

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            conv_start,
  input logic [CH_W-1:0] conv_chan,
  input logic            conv_done,
  input logic            scan_done,
  input logic            store,
  input logic            trig_evt,
  input logic            pwr_down,
  input logic            act_cont,
  input logic [NCH-1:0]  act_mask,
  input logic [NCH-1:0]  cmp_flag,
  input logic [NCH-1:0]  clr_vec
);

  // R2: every start names a channel enabled in the mask that chose it
  p_start_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ((($past(act_mask) >> conv_chan) & NCH'(1)) != '0));

  // R4: end-of-pass pulse only follows a store
  p_done_after_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> $past(store));

  // R4: single mode drops busy with the end-of-pass pulse
  p_single_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && !$past(act_cont)) |-> !busy);

  // R7: a flag only falls when a clear was written
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(cmp_flag) & ~$past(clr_vec)) & ~cmp_flag) == '0));

  // R9: a start comes from a done, or from a trigger seen while idle
  p_start_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ($past(conv_done) || ($past(trig_evt) && !$past(busy))));

  // R10: power-down empties the pipeline on the next cycle
  p_pd_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (!busy && !conv_start));

endmodule

bind adc_scan_ctrl adc_scan_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .conv_start(conv_start),
  .conv_chan(conv_chan), .conv_done(conv_done), .scan_done(scan_done),
  .store(store), .trig_evt(trig_evt), .pwr_down(pwr_down),
  .act_cont(act_cont), .act_mask(act_mask), .cmp_flag(cmp_flag),
  .clr_vec(clr_vec)
);

// File: tb/adc_scan_ctrl_test.sv
`timescale 1ns/1ps
module adc_scan_ctrl_test;

  localparam int NCH = 8, RES_W = 10, NTRIG = 4;
  localparam int WD = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCH-1:0]   en_mask = '0;
  logic             cont_mode = 1'b0;
  logic [1:0]       trig_sel = '0;
  logic             trig_pol = 1'b1;
  logic             cfg_update = 1'b0;
  logic             wr_en = 1'b0;
  logic [3:0]       wr_addr = '0;
  logic [WD-1:0]    wr_data = '0;
  logic [NTRIG-1:0] trig_in = '0;
  logic             pwr_down = 1'b0;
  logic             conv_start;
  logic [2:0]       conv_chan;
  logic             conv_done = 1'b0;
  logic [RES_W-1:0] conv_data = '0;
  logic [NCH*RES_W-1:0] res_flat;
  logic [NCH-1:0]   cmp_flag;
  logic             scan_done;
  logic             busy;

  adc_scan_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en_mask(en_mask), .cont_mode(cont_mode),
    .trig_sel(trig_sel), .trig_pol(trig_pol), .cfg_update(cfg_update),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .trig_in(trig_in),
    .pwr_down(pwr_down), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data), .res_flat(res_flat),
    .cmp_flag(cmp_flag), .scan_done(scan_done), .busy(busy)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int log_ch [0:255];
  int log_n = 0, n_start = 0, sd_cnt = 0, lat_fix = 0;
  bit finished = 0;

  // bench model of committed and staged configuration
  int stg_thr [NCH], act_thr [NCH];
  bit stg_en [NCH], act_en [NCH], stg_ge [NCH], act_ge [NCH];
  logic [NCH-1:0] m_mask = '0;
  int exp_res [NCH];
  logic [NCH-1:0] exp_flag = '0;

  function automatic bit meets(int code, int limit, bit en, bit ge);
    if (!en) return 0;
    if (ge) return !(code < limit);
    return limit > code;
  endfunction

  function automatic int order_at(logic [NCH-1:0] m, int k);
    int seen = 0;
    for (int i = 0; i < NCH; i++) begin
      if (m[i]) begin
        if (seen == k) return i;
        seen++;
      end
    end
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // conversion engine model
  initial begin
    forever begin
      @(negedge clk);
      while (conv_start) begin
        automatic int ch = int'(conv_chan);
        automatic int lat = (lat_fix != 0) ? lat_fix : 1 + int'($urandom % 3);
        automatic logic [RES_W-1:0] d = RES_W'($urandom);
        if (log_n < 256) log_ch[log_n] = ch;
        log_n++;
        n_start++;
        repeat (lat) @(negedge clk);
        conv_data = d;
        conv_done = 1'b1;
        if (!pwr_down) begin
          exp_res[ch] = int'(d);
          if (meets(int'(d), act_thr[ch], act_en[ch], act_ge[ch]))
            exp_flag[ch] = 1'b1;
        end
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (scan_done) sd_cnt++;
    end
  end

  task automatic wr(input int addr, input logic [WD-1:0] data);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = 4'(addr);
    wr_data = data;
    if (addr < NCH) begin
      stg_thr[addr] = int'(data[RES_W-1:0]);
      stg_ge[addr]  = data[RES_W];
      stg_en[addr]  = data[RES_W+1];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic commit(input logic [NCH-1:0] m, input bit c,
                        input logic [1:0] s, input bit p);
    @(negedge clk);
    en_mask = m; cont_mode = c; trig_sel = s; trig_pol = p;
    cfg_update = 1'b1;
    m_mask = m;
    for (int i = 0; i < NCH; i++) begin
      act_thr[i] = stg_thr[i]; act_en[i] = stg_en[i]; act_ge[i] = stg_ge[i];
    end
    @(negedge clk);
    cfg_update = 1'b0;
  endtask

  task automatic fire(input int s, input bit p);
    trig_in[s] = 1'b1;
    repeat (4) @(negedge clk);
    trig_in[s] = 1'b0;
    repeat (4) @(negedge clk);
    if (p) begin end
  endtask

  task automatic wait_idle(input string req);
    int k = 0;
    @(negedge clk);
    while (busy && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk(!busy, req, "busy stuck", busy, 0);
  endtask

  task automatic check_pass(input string req, input int sd0);
    int n = $countones(m_mask);
    chk(log_n == n, req, "start count", log_n, n);
    for (int k = 0; k < n && k < 256; k++)
      chk(log_ch[k] == order_at(m_mask, k), "R2", "channel order",
          log_ch[k], order_at(m_mask, k));
    chk(sd_cnt - sd0 == 1, "R4", "scan_done pulses", sd_cnt - sd0, 1);
    for (int i = 0; i < NCH; i++)
      chk(int'(res_flat[i*RES_W +: RES_W]) == exp_res[i], "R3", "result",
          res_flat[i*RES_W +: RES_W], exp_res[i]);
    chk(cmp_flag == exp_flag, "R7", "flags", cmp_flag, exp_flag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NCH; i++) begin
      stg_thr[i] = 0; act_thr[i] = 0; stg_en[i] = 0; act_en[i] = 0;
      stg_ge[i] = 0; act_ge[i] = 0; exp_res[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !conv_start && !scan_done, "R1", "ctrl outputs",
        {busy, conv_start, scan_done}, 0);
    chk(cmp_flag == '0, "R1", "flags", cmp_flag, 0);
    chk(res_flat == '0, "R1", "results", res_flat, 0);

    // R2 R3 R6 R7: random passes with random trigger choice and polarity
    for (int it = 0; it < 16; it++) begin
      automatic logic [NCH-1:0] m = NCH'(1 + $urandom % 255);
      automatic logic [1:0] s = 2'($urandom);
      automatic bit p = bit'($urandom % 2);
      automatic logic [NCH-1:0] clr = NCH'($urandom);
      automatic int sd0;
      for (int i = 0; i < NCH; i++)
        wr(i, {($urandom % 4) != 0, 1'($urandom), RES_W'($urandom)});
      if (!p) trig_in[s] = 1'b1;
      commit(m, 1'b0, s, p);
      repeat (4) @(negedge clk);
      wr(NCH, WD'(clr));
      exp_flag = exp_flag & ~clr;
      @(negedge clk);
      chk(cmp_flag == exp_flag, "R7", "w1c clear", cmp_flag, exp_flag);
      log_n = 0;
      sd0 = sd_cnt;
      if (p) fire(int'(s), p);
      else begin
        trig_in[s] = 1'b0;
        repeat (4) @(negedge clk);
      end
      wait_idle("R4");
      check_pass("R6", sd0);
    end

    // R6 latency and unselected line
    wr(0, {1'b0, 1'b0, RES_W'(0)});
    commit(8'h01, 1'b0, 2'd2, 1'b1);
    repeat (3) @(negedge clk);
    begin
      automatic int s0 = n_start;
      trig_in[1] = 1'b1;
      repeat (6) @(negedge clk);
      trig_in[1] = 1'b0;
      repeat (6) @(negedge clk);
      chk(n_start == s0 && !busy, "R6", "unselected line started", n_start, s0);
      trig_in[2] = 1'b1;
      repeat (2) @(negedge clk);
      chk(!conv_start, "R6", "start too early", conv_start, 0);
      @(negedge clk);
      chk(conv_start && conv_chan == 3'd0, "R6", "start at third edge",
          conv_start, 1);
      trig_in[2] = 1'b0;
      wait_idle("R6");
    end

    // R8: staged values stay inert until commit
    commit(8'b0101_0010, 1'b0, 2'd0, 1'b1);
    for (int i = 0; i < NCH; i++) begin
      exp_res[i] = exp_res[i];
    end
    wr(NCH, WD'({NCH{1'b1}}));
    exp_flag = '0;
    for (int i = 0; i < NCH; i++) wr(i, {1'b1, 1'b1, RES_W'(0)});
    @(negedge clk);
    en_mask = 8'hFF; trig_sel = 2'd3; cont_mode = 1'b1;
    begin
      automatic int sd0 = sd_cnt;
      log_n = 0;
      fire(0, 1'b1);
      wait_idle("R8");
      check_pass("R8", sd0);
      repeat (6) @(negedge clk);
      chk(!busy && sd_cnt == sd0 + 1, "R8", "uncommitted cont mode",
          sd_cnt - sd0, 1);
      log_n = 0;
      fire(3, 1'b1);
      chk(log_n == 0 && !busy, "R8", "uncommitted trig_sel", log_n, 0);
    end

    // R9: trigger while busy is ignored
    lat_fix = 3;
    commit(8'hFF, 1'b0, 2'd0, 1'b1);
    begin
      automatic int s0 = n_start, sd0 = sd_cnt;
      log_n = 0;
      fire(0, 1'b1);
      chk(busy, "R9", "busy during pass", busy, 1);
      fire(0, 1'b1);
      wait_idle("R9");
      repeat (8) @(negedge clk);
      chk(n_start - s0 == 8, "R9", "extra starts", n_start - s0, 8);
      chk(sd_cnt - sd0 == 1 && !busy, "R9", "extra pass", sd_cnt - sd0, 1);
    end
    lat_fix = 0;

    // R5: continuous passes, then commit single mode
    commit(8'b1010_0110, 1'b1, 2'd1, 1'b1);
    begin
      automatic int sd0 = sd_cnt, k = 0, np;
      log_n = 0;
      fire(1, 1'b1);
      while (sd_cnt < sd0 + 3 && k < 5000) begin
        @(negedge clk);
        k++;
      end
      chk(sd_cnt >= sd0 + 3, "R5", "passes repeat", sd_cnt - sd0, 3);
      commit(8'b1010_0110, 1'b0, 2'd1, 1'b1);
      wait_idle("R5");
      repeat (8) @(negedge clk);
      np = sd_cnt - sd0;
      chk(!busy && (np == 3 || np == 4 || np == 5), "R5", "stop after commit",
          np, 4);
      chk(log_n == np * 4, "R5", "starts per pass", log_n, np * 4);
      for (int j = 0; j < log_n && j < 256; j++)
        chk(log_ch[j] == order_at(m_mask, j % 4), "R5", "cyclic order",
            log_ch[j], order_at(m_mask, j % 4));
    end

    // R11: empty mask
    commit(8'h00, 1'b0, 2'd0, 1'b1);
    begin
      automatic int s0 = n_start;
      fire(0, 1'b1);
      chk(!busy && n_start == s0, "R11", "empty mask started", n_start - s0, 0);
    end

    // R10: power-down mid-scan
    lat_fix = 3;
    commit(8'hFF, 1'b0, 2'd0, 1'b1);
    trig_in[0] = 1'b1;
    repeat (8) @(negedge clk);
    trig_in[0] = 1'b0;
    begin
      automatic logic [NCH*RES_W-1:0] r0 = res_flat;
      automatic logic [NCH-1:0] f0 = cmp_flag;
      automatic int s0;
      chk(busy, "R10", "busy before power-down", busy, 1);
      pwr_down = 1'b1;
      @(negedge clk);
      chk(!busy && !conv_start, "R10", "halt", {busy, conv_start}, 0);
      s0 = n_start;
      fire(0, 1'b1);
      chk(!busy && n_start == s0, "R10", "trigger in power-down",
          n_start - s0, 0);
      chk(res_flat == r0, "R10", "results held", res_flat, r0);
      chk(cmp_flag == f0, "R10", "flags held", cmp_flag, f0);
      pwr_down = 1'b0;
      repeat (4) @(negedge clk);
    end
    lat_fix = 0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule